// File: doc/BRIEF.md
# Hall Sensor Commutation Event Generator

This block takes three Hall sensor lines of a brushless motor, already synchronized to the core clock, and marks the moments around each commutation. Any change on the three lines raises a common phase flag. Each line also raises a flag of its own. From the length of the phase interval that just ended, the block predicts when the next change will come and raises an early flag a programmed number of cycles before it. A delay flag follows a programmed number of cycles after either the change itself or the early flag. A stall watchdog flags a rotor that has stopped turning. The rotation direction is decoded from the six-step code sequence.

The seven flags are sticky and are cleared by writing ones to a clear vector. Three independent enable masks route them onto a one-cycle trigger pulse, a level interrupt request and a level DMA request. Motor control firmware uses the early and delay flags to schedule commutation or sampling relative to the sensor edges.

Top module: `hall_phase_events`

## Requirements
- R1: Flag bit 5 (phase) sets at the clock edge at which the value of {hall_u, hall_v, hall_w} differs from its value at the previous edge.
- R2: Flag bits 2, 1 and 0 set at the edge at which hall_u, hall_v and hall_w respectively change.
- R3: Flag bit 4 (early) sets once per interval, pre_cycles edges before the next change is expected, that is, N - pre_cycles edges after a change when the interval that ended at that change was N edges long. It does not set when N <= pre_cycles, before the second change after reset, or at an edge where a change occurs.
- R4: With dly_after_pre = 0, flag bit 3 (delay) sets dly_cycles edges after a change (at the change edge itself when dly_cycles = 0). A further change restarts the count.
- R5: With dly_after_pre = 1, flag bit 3 sets dly_cycles edges after the edge at which flag bit 4 was raised.
- R6: With stall_en = 1 and stall_limit = T > 0, flag bit 6 (stall) sets at the T-th edge after the last change and no earlier. A change at that edge restarts the count and no flag sets. With stall_en = 0 the count is held at zero.
- R7: Writing a one to flag_clear[i] clears flag i at the next edge. A set event for flag i at the same edge wins over the clear. Otherwise a flag stays set.
- R8: trig_out is a one-cycle pulse after any edge at which a flag with its trig_mask bit set receives a set event.
- R9: irq_out and dma_req are high exactly while some set flag has its irq_mask bit or dma_mask bit set, respectively.
- R10: The forward sequence of {u,v,w} is 001, 011, 010, 110, 100, 101, then back to 001. A change to the next code in this sequence clears dir_reverse, and a change to the previous code sets it. Any other change, or any change from or to 000 or 111, leaves dir_reverse unchanged.
- R11: After reset all flags, trig_out, irq_out, dma_req and dir_reverse are 0. The first edge after reset only captures the inputs and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_u | input | 1 | Synchronized U sensor line |
| hall_v | input | 1 | Synchronized V sensor line |
| hall_w | input | 1 | Synchronized W sensor line |
| dly_after_pre | input | 1 | Delay count start: 0 at a change, 1 at the early flag |
| dly_cycles | input | DLY_W | Delay length in clock cycles |
| pre_cycles | input | PRE_W | Lead of the early flag before the predicted change |
| stall_en | input | 1 | Stall watchdog enable |
| stall_limit | input | WDG_W | Stall timeout in clock cycles (0 never times out) |
| trig_mask | input | 7 | Per-flag enable for trig_out |
| irq_mask | input | 7 | Per-flag enable for irq_out |
| dma_mask | input | 7 | Per-flag enable for dma_req |
| flag_clear | input | 7 | Write-one-to-clear strobes for the flags |
| flags | output | 7 | Sticky flags: 6 stall, 5 phase, 4 early, 3 delay, 2 U, 1 V, 0 W |
| dir_reverse | output | 1 | 1 reverse rotation, 0 forward |
| trig_out | output | 1 | One-cycle trigger pulse |
| irq_out | output | 1 | Interrupt request level |
| dma_req | output | 1 | DMA request level |

## Verification
The collision that matters most is a clear and a set in the same cycle. The bench clears every flag at each sensor change, so the phase, per-line and zero-length delay flags must survive that clear while the stale early and stall flags must vanish. A second collision is the stall timeout falling on the very edge of a change: the sweep uses an interval equal to the timeout, and the expectation is that the stall flag never appears. With zero delay and the delay chained from the early flag, both flags are raised in one cycle. The bench checks that case against its arithmetic prediction and against a single merged trigger pulse.

// File: rtl/hall_evt_pkg.sv
package hall_evt_pkg;

    localparam int NFLAG = 7;

    // Bit positions of the flag vector (MSB first in the struct below)
    localparam int FB_STALL = 6;
    localparam int FB_PHASE = 5;
    localparam int FB_EARLY = 4;
    localparam int FB_DELAY = 3;
    localparam int FB_U     = 2;
    localparam int FB_V     = 1;
    localparam int FB_W     = 0;

    typedef struct packed {
        logic stall;
        logic phase;
        logic early;
        logic delay;
        logic u;
        logic v;
        logic w;
    } hall_flags_t;

    typedef logic [2:0] hall_code_t;   // {u, v, w}

    typedef enum logic [1:0] {
        STEP_FWD  = 2'd0,
        STEP_REV  = 2'd1,
        STEP_HOLD = 2'd2
    } step_verdict_t;

    localparam logic [2:0] STEP_BAD = 3'd7;

    // Position of a code in the forward six-step sequence, STEP_BAD if invalid
    function automatic logic [2:0] step_pos(input hall_code_t c);
        logic [2:0] p;
        case (c)
            3'b001:  p = 3'd0;
            3'b011:  p = 3'd1;
            3'b010:  p = 3'd2;
            3'b110:  p = 3'd3;
            3'b100:  p = 3'd4;
            3'b101:  p = 3'd5;
            default: p = STEP_BAD;
        endcase
        return p;
    endfunction

    function automatic logic [2:0] step_succ(input logic [2:0] p);
        return (p == 3'd5) ? 3'd0 : p + 3'd1;
    endfunction

    function automatic step_verdict_t judge_step(input hall_code_t from_c,
                                                 input hall_code_t to_c);
        logic [2:0]    pa;
        logic [2:0]    pb;
        step_verdict_t v;
        pa = step_pos(from_c);
        pb = step_pos(to_c);
        v  = STEP_HOLD;
        if (pa != STEP_BAD && pb != STEP_BAD) begin
            if (step_succ(pa) == pb)      v = STEP_FWD;
            else if (step_succ(pb) == pa) v = STEP_REV;
        end
        return v;
    endfunction

endpackage

// File: rtl/hall_state_tracker.sv
module hall_state_tracker
    import hall_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  hall_code_t code_in,
    output logic [2:0] toggled,
    output logic       any_toggle,
    output logic       dir_reverse
);

    hall_code_t prev_q;
    logic       primed_q;
    logic       dir_q;

    always_comb begin
        toggled    = primed_q ? (code_in ^ prev_q) : 3'b000;
        any_toggle = |toggled;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 3'b000;
            primed_q <= 1'b0;
            dir_q    <= 1'b0;
        end else begin
            prev_q   <= code_in;
            primed_q <= 1'b1;
            if (any_toggle) begin
                case (judge_step(prev_q, code_in))
                    STEP_FWD: dir_q <= 1'b0;
                    STEP_REV: dir_q <= 1'b1;
                    default:  dir_q <= dir_q;
                endcase
            end
        end
    end

    assign dir_reverse = dir_q;

endmodule

// File: rtl/hall_phase_predictor.sv
module hall_phase_predictor #(
    parameter int PRE_W = 24,
    parameter int DLY_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             toggle,
    input  logic             dly_after_pre,
    input  logic [PRE_W-1:0] pre_cycles,
    input  logic [DLY_W-1:0] dly_cycles,
    output logic             early_hit,
    output logic             delay_hit
);

    localparam int IVL_W = PRE_W;
    localparam logic [IVL_W:0]   LEN_ONE = 1;
    localparam logic [DLY_W-1:0] DLY_ONE = 1;

    // Interval measurement and early-flag prediction
    logic [IVL_W-1:0] ivl_q;
    logic [IVL_W:0]   ivl_len;
    logic [IVL_W:0]   target_q;
    logic             armed_q;
    logic             seen_edge_q;
    logic [IVL_W:0]   lead;

    assign ivl_len   = {1'b0, ivl_q} + LEN_ONE;
    assign lead      = {1'b0, pre_cycles};
    assign early_hit = armed_q && !toggle && (ivl_len == target_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ivl_q       <= '0;
            target_q    <= '0;
            armed_q     <= 1'b0;
            seen_edge_q <= 1'b0;
        end else if (toggle) begin
            ivl_q       <= '0;
            seen_edge_q <= 1'b1;
            if (seen_edge_q && (ivl_len > lead)) begin
                target_q <= ivl_len - lead;
                armed_q  <= 1'b1;
            end else begin
                armed_q  <= 1'b0;
            end
        end else begin
            if (!(&ivl_q)) ivl_q <= ivl_q + 1'b1;
            if (early_hit) armed_q <= 1'b0;
        end
    end

    // Delay countdown started by a change or by the early flag
    logic             dly_start;
    logic [DLY_W-1:0] rem_q;
    logic             run_q;

    assign dly_start = dly_after_pre ? early_hit : toggle;
    assign delay_hit = dly_start ? (dly_cycles == '0)
                                 : (run_q && (rem_q == DLY_ONE));

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            run_q <= 1'b0;
        end else if (dly_start) begin
            rem_q <= dly_cycles;
            run_q <= (dly_cycles != '0);
        end else if (run_q) begin
            rem_q <= rem_q - DLY_ONE;
            if (rem_q == DLY_ONE) run_q <= 1'b0;
        end
    end

endmodule

// File: rtl/hall_stall_watchdog.sv
module hall_stall_watchdog #(
    parameter int WDG_W = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             toggle,
    input  logic             enable,
    input  logic [WDG_W-1:0] limit,
    output logic             stall_hit
);

    localparam logic [WDG_W:0] CNT_ONE = 1;

    logic [WDG_W-1:0] cnt_q;
    logic             done_q;
    logic [WDG_W:0]   cnt_nxt;

    assign cnt_nxt   = {1'b0, cnt_q} + CNT_ONE;
    assign stall_hit = enable && !toggle && !done_q && (cnt_nxt == {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || toggle || !enable) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            cnt_q <= cnt_nxt[WDG_W-1:0];
            if (stall_hit) done_q <= 1'b1;
        end
    end

endmodule

// File: rtl/hall_flag_bank.sv
module hall_flag_bank
    import hall_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  hall_flags_t      set_evt,
    input  logic [NFLAG-1:0] clr,
    input  logic [NFLAG-1:0] trig_en,
    input  logic [NFLAG-1:0] irq_en,
    input  logic [NFLAG-1:0] dma_en,
    output logic [NFLAG-1:0] flags,
    output logic             trig,
    output logic             irq,
    output logic             dma
);

    logic [NFLAG-1:0] set_v;
    logic             trig_q;

    assign set_v = set_evt;

    for (genvar b = 0; b < NFLAG; b++) begin : g_flag
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)           bit_q <= 1'b0;
            else if (set_v[b]) bit_q <= 1'b1;
            else if (clr[b])   bit_q <= 1'b0;
        end
        assign flags[b] = bit_q;
    end

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= |(set_v & trig_en);
    end

    assign trig = trig_q;
    assign irq  = |(flags & irq_en);
    assign dma  = |(flags & dma_en);

endmodule

// File: rtl/hall_phase_events.sv
module hall_phase_events
    import hall_evt_pkg::*;
#(
    parameter int PRE_W = 24,
    parameter int DLY_W = 24,
    parameter int WDG_W = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hall_u,
    input  logic             hall_v,
    input  logic             hall_w,
    input  logic             dly_after_pre,
    input  logic [DLY_W-1:0] dly_cycles,
    input  logic [PRE_W-1:0] pre_cycles,
    input  logic             stall_en,
    input  logic [WDG_W-1:0] stall_limit,
    input  logic [6:0]       trig_mask,
    input  logic [6:0]       irq_mask,
    input  logic [6:0]       dma_mask,
    input  logic [6:0]       flag_clear,
    output logic [6:0]       flags,
    output logic             dir_reverse,
    output logic             trig_out,
    output logic             irq_out,
    output logic             dma_req
);

    hall_code_t  code;
    logic [2:0]  toggled;
    logic        any_toggle;
    logic        early_hit;
    logic        delay_hit;
    logic        stall_hit;
    hall_flags_t set_evt;

    assign code = {hall_u, hall_v, hall_w};

    hall_state_tracker u_track (
        .clk        (clk),
        .rst        (rst),
        .code_in    (code),
        .toggled    (toggled),
        .any_toggle (any_toggle),
        .dir_reverse(dir_reverse)
    );

    hall_phase_predictor #(
        .PRE_W(PRE_W),
        .DLY_W(DLY_W)
    ) u_pred (
        .clk          (clk),
        .rst          (rst),
        .toggle       (any_toggle),
        .dly_after_pre(dly_after_pre),
        .pre_cycles   (pre_cycles),
        .dly_cycles   (dly_cycles),
        .early_hit    (early_hit),
        .delay_hit    (delay_hit)
    );

    hall_stall_watchdog #(
        .WDG_W(WDG_W)
    ) u_wdog (
        .clk      (clk),
        .rst      (rst),
        .toggle   (any_toggle),
        .enable   (stall_en),
        .limit    (stall_limit),
        .stall_hit(stall_hit)
    );

    always_comb begin
        set_evt.stall = stall_hit;
        set_evt.phase = any_toggle;
        set_evt.early = early_hit;
        set_evt.delay = delay_hit;
        set_evt.u     = toggled[2];
        set_evt.v     = toggled[1];
        set_evt.w     = toggled[0];
    end

    hall_flag_bank u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_evt(set_evt),
        .clr    (flag_clear),
        .trig_en(trig_mask),
        .irq_en (irq_mask),
        .dma_en (dma_mask),
        .flags  (flags),
        .trig   (trig_out),
        .irq    (irq_out),
        .dma    (dma_req)
    );

endmodule

// File: rtl/hall_phase_events_chk.sv
module hall_phase_events_chk (
    input logic       clk,
    input logic       rst,
    input logic       hall_u,
    input logic       hall_v,
    input logic       hall_w,
    input logic       stall_en,
    input logic [6:0] trig_mask,
    input logic [6:0] flag_clear,
    input logic [6:0] flags,
    input logic       dir_reverse,
    input logic       trig_out,
    input logic       irq_out,
    input logic       dma_req
);

    logic [2:0] code;
    logic       live_q;

    assign code = {hall_u, hall_v, hall_w};

    always_ff @(posedge clk) begin
        live_q <= !rst;
    end

    AST_PHASE_ON_CHANGE : assert property (@(posedge clk) disable iff (rst) (live_q && code != $past(code)) |=> flags[5]); // R1
    AST_U_ON_CHANGE     : assert property (@(posedge clk) disable iff (rst) (live_q && hall_u != $past(hall_u)) |=> flags[2]); // R2
    AST_NO_EARLY_AT_CHG : assert property (@(posedge clk) disable iff (rst) (live_q && code != $past(code) && flag_clear[4]) |=> !flags[4]); // R3
    AST_STALL_NEEDS_EN  : assert property (@(posedge clk) disable iff (rst) $rose(flags[6]) |-> $past(stall_en)); // R6
    AST_FLAG_STICKY     : assert property (@(posedge clk) disable iff (rst) (flags[5] && !flag_clear[5]) |=> flags[5]); // R7
    AST_TRIG_MASKED     : assert property (@(posedge clk) disable iff (rst) trig_out |-> |(flags & $past(trig_mask))); // R8
    AST_REQ_QUIET       : assert property (@(posedge clk) disable iff (rst) (flags == 7'd0) |-> (!irq_out && !dma_req)); // R9
    AST_DIR_HOLD        : assert property (@(posedge clk) disable iff (rst) (live_q && code == $past(code)) |=> $stable(dir_reverse)); // R10

endmodule

bind hall_phase_events hall_phase_events_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .hall_u     (hall_u),
    .hall_v     (hall_v),
    .hall_w     (hall_w),
    .stall_en   (stall_en),
    .trig_mask  (trig_mask),
    .flag_clear (flag_clear),
    .flags      (flags),
    .dir_reverse(dir_reverse),
    .trig_out   (trig_out),
    .irq_out    (irq_out),
    .dma_req    (dma_req)
);

// File: tb/test_hall_phase_events.sv
module test_hall_phase_events;

    logic        clk = 1'b0;
    logic        rst;
    logic        hall_u, hall_v, hall_w;
    logic        dly_after_pre;
    logic [23:0] dly_cycles;
    logic [23:0] pre_cycles;
    logic        stall_en;
    logic [30:0] stall_limit;
    logic [6:0]  trig_mask, irq_mask, dma_mask, flag_clear;
    logic [6:0]  flags;
    logic        dir_reverse, trig_out, irq_out, dma_req;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    hall_phase_events i_hall_phase_events (
        .clk(clk), .rst(rst),
        .hall_u(hall_u), .hall_v(hall_v), .hall_w(hall_w),
        .dly_after_pre(dly_after_pre), .dly_cycles(dly_cycles),
        .pre_cycles(pre_cycles), .stall_en(stall_en), .stall_limit(stall_limit),
        .trig_mask(trig_mask), .irq_mask(irq_mask), .dma_mask(dma_mask),
        .flag_clear(flag_clear), .flags(flags), .dir_reverse(dir_reverse),
        .trig_out(trig_out), .irq_out(irq_out), .dma_req(dma_req)
    );

    // Bench state
    logic [2:0] cur;
    bit         exp_dir;
    bit         have_prev;
    int         prev_len;
    int         n;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int seq_idx(input logic [2:0] c);
        logic [2:0] seqv [6] = '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101};
        int r;
        r = -1;
        for (int i = 0; i < 6; i++) if (seqv[i] == c) r = i;
        return r;
    endfunction

    function automatic logic [2:0] pick_next(input logic [2:0] c, input int cnt);
        logic [2:0] seqv [6] = '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101};
        int i;
        i = seq_idx(c);
        case (cnt % 7)
            0, 1, 2: return seqv[(i + 1) % 6];
            3:       return seqv[(i + 5) % 6];
            4:       return ~c;
            5:       return ((cnt / 7) % 2) ? 3'b111 : 3'b000;
            default: return 3'b011;
        endcase
    endfunction

    // Drive one change and hold it for L edges, checking every cycle.
    task automatic run_interval(input int L, input int P, input int D,
                                input bit sel, input bit wen, input int TO);
        logic [2:0] nxt;
        logic [2:0] tg;
        logic [6:0] ef;
        logic [6:0] ev;
        int oi, ni, kp, kd;
        string dname;
        nxt = pick_next(cur, n);
        tg  = cur ^ nxt;
        oi  = seq_idx(cur);
        ni  = seq_idx(nxt);
        if (oi >= 0 && ni >= 0) begin
            if (ni == (oi + 1) % 6)      exp_dir = 1'b0;
            else if (oi == (ni + 1) % 6) exp_dir = 1'b1;
        end
        kp = (have_prev && prev_len > P) ? prev_len - P : -1;
        if (sel) kd = (kp >= 0) ? kp + D : -1;
        else     kd = D;
        dname = sel ? "R5 delay-from-early" : "R4 delay-from-change";

        {hall_u, hall_v, hall_w} = nxt;
        dly_after_pre = sel;
        dly_cycles    = 24'(D);
        pre_cycles    = 24'(P);
        stall_en      = wen;
        stall_limit   = 31'(TO);
        trig_mask     = 7'((n * 23 + 5) & 127);
        irq_mask      = 7'((n * 37 + 9) & 127);
        dma_mask      = 7'((n * 53 + 66) & 127);
        flag_clear    = 7'h7F;

        for (int k = 0; k < L; k++) begin
            @(negedge clk);
            if (k == 0) flag_clear = 7'h00;
            ef = {wen && TO > 0 && k >= TO, 1'b1, kp >= 0 && k >= kp,
                  kd >= 0 && k >= kd, tg};
            ev = {wen && TO > 0 && k == TO, k == 0, k == kp, k == kd,
                  (k == 0) ? tg : 3'b000};
            if (k == 0) chk("R7 clear-vs-set at change", int'(flags), int'(ef));
            chk("R6 stall flag",        int'(flags[6]), int'(ef[6]));
            chk("R1 phase flag",        int'(flags[5]), int'(ef[5]));
            chk("R3 early flag",        int'(flags[4]), int'(ef[4]));
            chk(dname,                  int'(flags[3]), int'(ef[3]));
            chk("R2 U flag",            int'(flags[2]), int'(ef[2]));
            chk("R2 V flag",            int'(flags[1]), int'(ef[1]));
            chk("R2 W flag",            int'(flags[0]), int'(ef[0]));
            chk("R8 trigger pulse",     int'(trig_out), int'(|(ev & trig_mask)));
            chk("R9 interrupt level",   int'(irq_out),  int'(|(ef & irq_mask)));
            chk("R9 dma level",         int'(dma_req),  int'(|(ef & dma_mask)));
            chk("R10 direction",        int'(dir_reverse), int'(exp_dir));
        end
        cur       = nxt;
        have_prev = 1'b1;
        prev_len  = L;
        n++;
    endtask

    initial begin
        rst = 1'b1;
        {hall_u, hall_v, hall_w} = 3'b001;
        dly_after_pre = 1'b0; dly_cycles = '0; pre_cycles = '0;
        stall_en = 1'b0; stall_limit = '0;
        trig_mask = 7'h7F; irq_mask = 7'h7F; dma_mask = 7'h7F; flag_clear = 7'h00;
        cur = 3'b001; exp_dir = 1'b0; have_prev = 1'b0; prev_len = 0; n = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 flags after reset", int'(flags), 0);
        chk("R11 trig after reset",  int'(trig_out), 0);
        chk("R11 irq after reset",   int'(irq_out), 0);
        chk("R11 dma after reset",   int'(dma_req), 0);
        chk("R11 dir after reset",   int'(dir_reverse), 0);
        repeat (3) @(negedge clk);
        chk("R11 no event from input capture", int'(flags), 0);
        chk("R11 trig idle", int'(trig_out), 0);

        // Delay from the change, stall enabled with limit 6
        for (int L = 1; L <= 8; L++)
            for (int P = 0; P <= 3; P++)
                for (int D = 0; D <= 4; D++)
                    run_interval(L, P, D, 1'b0, 1'b1, 6);

        // Delay chained from the early flag, stall disabled
        for (int rep = 0; rep < 3; rep++)
            for (int P = 1; P <= 4; P++)
                for (int D = 0; D < P; D++)
                    run_interval(10, P, D, 1'b1, 1'b0, 6);

        // Long stall
        run_interval(40, 2, 1, 1'b0, 1'b1, 25);
        run_interval(30, 2, 1, 1'b0, 1'b1, 25);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule